// File: doc/BRIEF.md
# Bit-Oriented Message Filter Receiver

This block watches a serial data-link bit stream for repeating 16-bit bit-oriented message patterns. A pattern is eight ones, then a zero, then a 6-bit code, then a closing zero. The receiver finds patterns by the run of eight ones. It keeps a history of the codes from the last ten aligned patterns. With the filter enabled, it accepts a code once that code fills at least seven of the ten history slots. On acceptance it writes two bytes into the receive FIFO: the code byte, then a status byte that marks a message frame. It also pulses the message-end interrupt.

After acceptance a live valid flag stays high. The flag drops, with a single pulse on the lost interrupt, in either of two cases: fewer than seven of the last ten patterns carry the accepted code, or 32 received bits pass without an aligned pattern. With the filter disabled, every aligned pattern is written to the FIFO and interrupts on its own, and the valid flag stays low. Recovering the data-link bits from the line framing is done elsewhere. This block only sees `bit_valid`/`bit_in`.

Top module: `bom_filter_rx`

## Requirements
- R1: After reset `fifo_wr`, `valid_bom`, `irq_msg_end` and `irq_bom_lost` are 0 and the filter is off until `filter_en` is driven high.
- R2: With `filter_en` low, each aligned pattern (bits in arrival order: 11111111, 0, c5..c0, 0) writes `{2'b00,code}` on the cycle after its last bit is sampled, then status byte 8'h01 on the next cycle, and pulses `irq_msg_end` with the first write.
- R3: With `filter_en` high, a code is accepted on the aligned pattern that makes it present in at least 7 of the last 10 aligned patterns, and not on an earlier one.
- R4: An acceptance writes the code byte and then the status byte 8'h01 (bit 0 marks a message frame), pulses `irq_msg_end` together with the code byte, and raises `valid_bom` in the same cycle.
- R5: While `valid_bom` is high, further patterns with the accepted code cause no FIFO write and no interrupt.
- R6: While valid, an aligned pattern that leaves the accepted code in fewer than 7 of the last 10 patterns clears `valid_bom` and pulses `irq_bom_lost` once. A different code can then be accepted once it reaches 7 of 10.
- R7: 32 consecutive valid bits with no aligned pattern clear the history and `valid_bom`, and pulse `irq_bom_lost` if the flag was set. 31 such bits have no effect.
- R8: A 16-bit window whose closing bit is 1 is not a pattern and causes no write.
- R9: Driving `filter_en` low clears `valid_bom` without a lost interrupt.
- R10: `irq_msg_end` and `irq_bom_lost` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | `bit_in` carries a data-link bit this cycle |
| bit_in | input | 1 | Serial data-link bit |
| filter_en | input | 1 | 7-of-10 filter enable |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_data | output | 8 | Receive FIFO write byte |
| valid_bom | output | 1 | A filtered message is currently valid |
| irq_msg_end | output | 1 | Message stored pulse |
| irq_bom_lost | output | 1 | Valid message lost pulse |

## Verification
Every result is registered once. The code byte, `irq_msg_end`, `valid_bom` and `irq_bom_lost` change at the clock edge that samples the closing bit of a pattern, or the 32nd idle bit, and the status byte follows one cycle later. The bench drives on falling edges. It reads `valid_bom` at the falling edge just after the deciding bit. It reads interrupt counts and the empty scoreboard queue only after one more falling edge, so the status byte has already been popped. The FIFO monitor compares each write as it appears, so a byte that comes one cycle early or late is paired with the wrong queue entry or shows up as an unexpected write.

// File: rtl/bom_filter_rx.sv
module bom_filter_rx #(
  parameter int CODE_W = 6,
  parameter int HIST   = 10,
  parameter int NEED   = 7,
  parameter int GAP    = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_valid,
  input  logic       bit_in,
  input  logic       filter_en,
  output logic       fifo_wr,
  output logic [7:0] fifo_data,
  output logic       valid_bom,
  output logic       irq_msg_end,
  output logic       irq_bom_lost
);
  localparam int PAT_W = CODE_W + 10;
  localparam int CNT_W = $clog2(HIST + 1);
  localparam int GAP_W = $clog2(GAP);
  localparam logic [7:0] STAT_BOM = 8'h01;

  logic [PAT_W-1:0]  sh, sh_nx;
  logic [CODE_W-1:0] code, acc_code;
  logic [CODE_W-1:0] hc [HIST];
  logic [HIST-1:0]   hv;
  logic [GAP_W-1:0]  gap;
  logic [CNT_W-1:0]  n_new, n_acc;
  logic pend, pat, timeout, accept, store, drop;

  assign sh_nx   = {sh[PAT_W-2:0], bit_in};
  assign code    = sh_nx[CODE_W:1];
  assign pat     = bit_valid && (sh_nx[PAT_W-1 -: 8] == 8'hFF) && !sh_nx[CODE_W+1] && !sh_nx[0];
  assign timeout = bit_valid && !pat && (gap == GAP_W'(GAP - 1));

  always_comb begin
    n_new = CNT_W'(1);
    n_acc = (code == acc_code) ? CNT_W'(1) : '0;
    for (int i = 0; i < HIST - 1; i++) begin
      if (hv[i] && hc[i] == code)     n_new = n_new + CNT_W'(1);
      if (hv[i] && hc[i] == acc_code) n_acc = n_acc + CNT_W'(1);
    end
  end

  assign accept = pat && filter_en && !valid_bom && (n_new >= CNT_W'(NEED));
  assign store  = pat && (!filter_en || accept);
  assign drop   = filter_en && valid_bom && ((pat && n_acc < CNT_W'(NEED)) || timeout);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST; i++) hc[i] <= '0;
    end else if (pat) begin
      hc[0] <= code;
      for (int i = 1; i < HIST; i++) hc[i] <= hc[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh           <= '0;
      hv           <= '0;
      gap          <= '0;
      acc_code     <= '0;
      pend         <= 1'b0;
      fifo_wr      <= 1'b0;
      fifo_data    <= '0;
      valid_bom    <= 1'b0;
      irq_msg_end  <= 1'b0;
      irq_bom_lost <= 1'b0;
    end else begin
      fifo_wr      <= 1'b0;
      irq_msg_end  <= 1'b0;
      irq_bom_lost <= 1'b0;
      pend         <= 1'b0;
      if (bit_valid) sh <= sh_nx;
      if (!filter_en) valid_bom <= 1'b0;
      if (pend) begin
        fifo_wr   <= 1'b1;
        fifo_data <= STAT_BOM;
      end
      if (pat) begin
        gap <= '0;
        hv  <= {hv[HIST-2:0], 1'b1};
      end else if (timeout) begin
        gap <= '0;
        hv  <= '0;
      end else if (bit_valid) begin
        gap <= gap + GAP_W'(1);
      end
      if (store) begin
        fifo_wr     <= 1'b1;
        fifo_data   <= {{(8-CODE_W){1'b0}}, code};
        pend        <= 1'b1;
        irq_msg_end <= 1'b1;
      end
      if (accept) begin
        valid_bom <= 1'b1;
        acc_code  <= code;
      end
      if (drop) begin
        valid_bom    <= 1'b0;
        irq_bom_lost <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bom_filter_rx_chk.sv
module bom_filter_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       filter_en,
  input logic       fifo_wr,
  input logic [7:0] fifo_data,
  input logic       valid_bom,
  input logic       irq_msg_end,
  input logic       irq_bom_lost
);
  a_r10_msg_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_msg_end |=> !irq_msg_end);
  a_r10_lost_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_bom_lost |=> !irq_bom_lost);
  a_r4_msg_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq_msg_end |-> fifo_wr);
  a_r4_status_byte: assert property (@(posedge clk) disable iff (!rst_n)
    irq_msg_end |=> (fifo_wr && fifo_data == 8'h01));
  a_r6_lost_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_bom_lost |-> ($past(valid_bom) && !valid_bom));
  a_r3_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_msg_end && $past(filter_en)) |-> valid_bom);
  a_r9_disabled_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(filter_en) |-> !valid_bom);
endmodule

bind bom_filter_rx bom_filter_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .filter_en(filter_en), .fifo_wr(fifo_wr),
  .fifo_data(fifo_data), .valid_bom(valid_bom), .irq_msg_end(irq_msg_end),
  .irq_bom_lost(irq_bom_lost)
);

// File: tb/bom_filter_rx_test.sv
module bom_filter_rx_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bit_valid = 1'b0, bit_in = 1'b0, filter_en = 1'b0;
  logic fifo_wr, valid_bom, irq_msg_end, irq_bom_lost;
  logic [7:0] fifo_data;

  int checks = 0, failures = 0, msg_cnt = 0, lost_cnt = 0;
  logic [7:0] exp_q[$];
  logic prev_msg = 1'b0, prev_lost = 1'b0;
  bit done = 1'b0;

  bom_filter_rx uut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .filter_en(filter_en), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .valid_bom(valid_bom), .irq_msg_end(irq_msg_end), .irq_bom_lost(irq_bom_lost)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_wr) begin
        if (exp_q.size() == 0) chk(1'b0, "R2/R4/R5 unexpected write", fifo_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(fifo_data == e, "R2/R4 fifo byte", fifo_data, e);
        end
      end
      if (irq_msg_end) begin
        msg_cnt++;
        chk(fifo_wr, "R4 msg_end with write", fifo_wr, 1);
      end
      if (irq_bom_lost) lost_cnt++;
      if (irq_msg_end && prev_msg) chk(1'b0, "R10 msg_end width", 2, 1);
      if (irq_bom_lost && prev_lost) chk(1'b0, "R10 lost width", 2, 1);
      prev_msg  = irq_msg_end;
      prev_lost = irq_bom_lost;
    end
  end

  task automatic send_bit(input logic b);
    bit_in = b;
    bit_valid = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_pat(input logic [5:0] c, input bit good);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 5; i >= 0; i--) send_bit(c[i]);
    send_bit(good ? 1'b0 : 1'b1);
  endtask

  task automatic expect_msg(input logic [5:0] c);
    exp_q.push_back({2'b00, c});
    exp_q.push_back(8'h01);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int m, l;
    repeat (3) @(negedge clk);
    chk(!fifo_wr && !valid_bom && !irq_msg_end && !irq_bom_lost, "R1 outputs in reset",
        {fifo_wr, valid_bom, irq_msg_end, irq_bom_lost}, 0);
    rst_n = 1'b1;
    settle();
    chk(!fifo_wr && !valid_bom, "R1 after reset", {fifo_wr, valid_bom}, 0);

    expect_msg(6'h2A); send_pat(6'h2A, 1'b1);
    expect_msg(6'h15); send_pat(6'h15, 1'b1);
    settle();
    chk(msg_cnt == 2, "R2 unfiltered msg count", msg_cnt, 2);
    chk(!valid_bom, "R2 valid low when unfiltered", valid_bom, 0);
    send_pat(6'h15, 1'b0);
    settle();
    chk(msg_cnt == 2 && exp_q.size() == 0, "R8 malformed ignored", msg_cnt, 2);

    filter_en = 1'b1;
    for (int i = 0; i < 6; i++) send_pat(6'h33, 1'b1);
    chk(!valid_bom, "R3 six of ten not accepted", valid_bom, 0);
    settle();
    chk(msg_cnt == 2, "R3 no write before seventh", msg_cnt, 2);
    expect_msg(6'h33); send_pat(6'h33, 1'b1);
    chk(valid_bom, "R4 valid on acceptance", valid_bom, 1);
    settle();
    chk(msg_cnt == 3 && exp_q.size() == 0, "R4 accepted message stored", msg_cnt, 3);

    for (int i = 0; i < 5; i++) send_pat(6'h33, 1'b1);
    settle();
    chk(msg_cnt == 3 && valid_bom, "R5 repeats not stored", msg_cnt, 3);

    for (int i = 0; i < 3; i++) send_pat(6'h0C, 1'b1);
    chk(valid_bom, "R6 still valid at seven of ten", valid_bom, 1);
    send_pat(6'h0C, 1'b1);
    chk(!valid_bom, "R6 valid cleared at six of ten", valid_bom, 0);
    settle();
    chk(lost_cnt == 1, "R6 lost pulse", lost_cnt, 1);
    send_pat(6'h0C, 1'b1); send_pat(6'h0C, 1'b1);
    expect_msg(6'h0C); send_pat(6'h0C, 1'b1);
    chk(valid_bom, "R6 new code accepted", valid_bom, 1);
    settle();
    chk(msg_cnt == 4 && exp_q.size() == 0, "R6 new code stored", msg_cnt, 4);

    for (int i = 0; i < 31; i++) send_bit(1'b0);
    chk(valid_bom, "R7 31 idle bits no effect", valid_bom, 1);
    send_bit(1'b0);
    chk(!valid_bom, "R7 timeout clears valid", valid_bom, 0);
    settle();
    chk(lost_cnt == 2, "R7 timeout lost pulse", lost_cnt, 2);
    for (int i = 0; i < 6; i++) send_pat(6'h0C, 1'b1);
    chk(!valid_bom, "R7 history cleared by timeout", valid_bom, 0);
    expect_msg(6'h0C); send_pat(6'h0C, 1'b1);
    chk(valid_bom, "R7 reaccepted after refill", valid_bom, 1);
    settle();

    m = msg_cnt; l = lost_cnt;
    filter_en = 1'b0;
    settle();
    chk(!valid_bom && lost_cnt == l, "R9 disable clears silently", lost_cnt, l);
    expect_msg(6'h3F); send_pat(6'h3F, 1'b1);
    settle();
    chk(msg_cnt == m + 1 && exp_q.size() == 0, "R2 all-ones code stored", msg_cnt, m + 1);
    chk(lost_cnt == l, "R10 no stray lost pulses", lost_cnt, l);
    report();
  end
endmodule